// File: doc/BRIEF.md
# PCM Timeslot Serial Port

This block moves 8-bit companded voice samples between a set of codec channels and two serial PCM highways. An external bit clock and an 8 kHz frame-sync pulse define the frame. Each frame is split into consecutive 8-bit timeslots, with up to 128 slots per frame. Every channel has its own transmit slot and its own receive slot. It also has two select bits: one picks the transmit highway (DX1 or DX2) and the other picks the receive highway (DR1 or DR2).

The block runs on a fast system clock, `clk_i`. It treats `bclk_i`, `fs_i` and the two receive lines as asynchronous inputs. It passes them through a synchronizer and works on the detected bit-clock edges. Transmit data changes after a rising bit-clock edge. Receive data is sampled at a falling edge. Both directions are MSB first.

The transmit outputs stay in high impedance until the first frame sync is seen. Each highway has an active-low open-drain slot indicator. The indicator pulls low exactly while that highway is being driven.

Top module: `pcm_ts_port`

## Requirements
- R1: A frame begins when `fs_i` is high at a falling `bclk_i` edge. Bit 0 of slot 0 starts at the next rising edge, and slot counting restarts from there whatever the length of the previous frame.
- R2: From reset until the first frame sync, `dx1_oe_o` and `dx2_oe_o` stay low and `tsx1_no`/`tsx2_no` stay high. This holds whatever the configuration.
- R3: A channel sends its `tx_data_i` byte MSB first in the slot given by `tx_slot_i`. Bit k of the slot is held from the k-th rising edge of that slot. `tx_hw_i`=0 selects DX1 and 1 selects DX2.
- R4: A highway's output enable is high only during bits that belong to a channel mapped to that highway. During such a slot the other highway stays released unless another channel owns it. If two channels on one highway share a slot, the lower channel index wins.
- R5: `tsx1_no` is low exactly while `dx1_oe_o` is high, and `tsx2_no` is low exactly while `dx2_oe_o` is high. Otherwise both are high (released).
- R6: A channel shifts in its receive slot MSB first at falling edges. It reads `dr1_i` when `rx_hw_i`=0 and `dr2_i` when it is 1. After the last bit it presents the byte on `rx_data_o` with a `rx_valid_o` pulse one `clk_i` cycle wide.
- R7: A slot number equal to or above the number of slots in the current frame disables that direction for that frame. No driving occurs and no valid pulse is issued.
- R8: Slot numbers and highway selects are captured at the frame sync. A change made during a frame takes effect only from the following frame.
- R9: The transmit byte is captured at the first bit of the channel's slot. A change to `tx_data_i` later in that slot does not alter the bits sent.
- R10: Frames of 128 slots are supported, and slot 127 works in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | PCM bit clock |
| fs_i | input | 1 | Frame sync, one bit clock wide before slot 0 |
| dr1_i | input | 1 | Receive highway 1 |
| dr2_i | input | 1 | Receive highway 2 |
| tx_data_i | input | N_CH*8 | Transmit byte per channel |
| tx_slot_i | input | N_CH*7 | Transmit slot number per channel |
| tx_hw_i | input | N_CH | Transmit highway select per channel (0 = DX1) |
| rx_slot_i | input | N_CH*7 | Receive slot number per channel |
| rx_hw_i | input | N_CH | Receive highway select per channel (0 = DR1) |
| dx1_o | output | 1 | Transmit highway 1 data |
| dx1_oe_o | output | 1 | Drive enable for highway 1 |
| dx2_o | output | 1 | Transmit highway 2 data |
| dx2_oe_o | output | 1 | Drive enable for highway 2 |
| tsx1_no | output | 1 | Open-drain slot indicator for highway 1, low = pulling |
| tsx2_no | output | 1 | Open-drain slot indicator for highway 2, low = pulling |
| rx_data_o | output | N_CH*8 | Last received byte per channel |
| rx_valid_o | output | N_CH | One-cycle strobe per channel when a byte is complete |

## Verification
The configuration capture at the frame sync falls on the same falling bit-clock edge as the receive sample of the final bit of the last slot. It also lands while a channel in that last slot is still transmitting. The bench provokes this by placing transmit and receive channels in the last slot of a frame. It then changes highway selects and the next frame's configuration before that final edge, including a flip made in the middle of a frame. The check passes only if the byte in progress completes on its old highway with the old slot mapping and the new mapping appears only in the next frame.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int SAMPLE_W = 8;
  localparam int SLOT_W   = 7;
  localparam int BIT_W    = $clog2(SAMPLE_W);
  // slot counter has one extra bit; its top value means "past every slot"
  localparam logic [SLOT_W:0] SLOT_END = {1'b1, {SLOT_W{1'b0}}};
endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              fs_i,
  input  logic [1:0]        dr_i,
  output logic              running_o,
  output logic              cfg_load_o,
  output logic              bit_tick_o,
  output logic              samp_tick_o,
  output logic [SLOT_W:0]   slot_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic [1:0]        dr_o
);
  // sample word: {bclk, fs, dr2, dr1}
  logic [SYNC_STAGES-1:0][3:0] sync_q;
  logic [3:0] s;
  logic bclk_d, rise, fall, armed_q, frame_start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else begin
      sync_q[0] <= {bclk_i, fs_i, dr_i[1], dr_i[0]};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign s    = sync_q[SYNC_STAGES-1];
  assign rise = s[3] & ~bclk_d;
  assign fall = ~s[3] & bclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_d        <= 1'b0;
      armed_q       <= 1'b0;
      running_o     <= 1'b0;
      cfg_load_o    <= 1'b0;
      bit_tick_o    <= 1'b0;
      samp_tick_o   <= 1'b0;
      frame_start_q <= 1'b0;
      slot_o        <= SLOT_END;
      bit_o         <= '0;
      dr_o          <= '0;
    end else begin
      bclk_d        <= s[3];
      bit_tick_o    <= rise;
      samp_tick_o   <= fall & running_o;
      cfg_load_o    <= 1'b0;
      frame_start_q <= 1'b0;
      if (fall) begin
        dr_o <= s[1:0];
        if (s[2]) begin
          armed_q    <= 1'b1;
          cfg_load_o <= 1'b1;
        end
      end
      if (rise) begin
        if (armed_q) begin
          armed_q       <= 1'b0;
          running_o     <= 1'b1;
          frame_start_q <= 1'b1;
          slot_o        <= '0;
          bit_o         <= '0;
        end else if (running_o) begin
          bit_o <= bit_o + 1'b1;
          if (bit_o == BIT_W'(SAMPLE_W-1) && slot_o != SLOT_END) slot_o <= slot_o + 1'b1;
        end
      end
    end
  end

  // R1
  start_after_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_q |-> $past(armed_q) && slot_o == '0 && bit_o == '0);
  // R10
  slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o <= SLOT_END);
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_tick_i,
  input  logic                running_i,
  input  logic [SLOT_W:0]     slot_i,
  input  logic [BIT_W-1:0]    bit_i,
  input  logic [SLOT_W-1:0]   cfg_slot_i,
  input  logic                cfg_hw_i,
  input  logic [SAMPLE_W-1:0] data_i,
  output logic                act_o,
  output logic                hw_o,
  output logic                bit_o
);
  logic [SAMPLE_W-1:0] sh_q;
  logic hit;

  assign hit   = running_i && bit_i == '0 && slot_i == {1'b0, cfg_slot_i};
  assign bit_o = sh_q[SAMPLE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      act_o <= 1'b0;
      hw_o  <= 1'b0;
    end else if (bit_tick_i) begin
      if (hit) begin
        sh_q  <= data_i;      // byte and highway frozen for the whole slot
        act_o <= 1'b1;
        hw_o  <= cfg_hw_i;
      end else if (bit_i == '0) act_o <= 1'b0;
      else sh_q <= {sh_q[SAMPLE_W-2:0], 1'b0};
    end
  end

  // R9
  slot_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_i && hit |=> act_o && bit_o == $past(data_i[SAMPLE_W-1]));
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                samp_tick_i,
  input  logic                running_i,
  input  logic [SLOT_W:0]     slot_i,
  input  logic [BIT_W-1:0]    bit_i,
  input  logic [SLOT_W-1:0]   cfg_slot_i,
  input  logic                cfg_hw_i,
  input  logic [1:0]          dr_i,
  output logic [SAMPLE_W-1:0] data_o,
  output logic                valid_o
);
  logic [SAMPLE_W-1:0] sh_q;
  logic in_slot, din;

  assign in_slot = running_i && slot_i == {1'b0, cfg_slot_i};
  assign din     = dr_i[cfg_hw_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (samp_tick_i && in_slot) begin
        sh_q <= {sh_q[SAMPLE_W-2:0], din};
        if (bit_i == BIT_W'(SAMPLE_W-1)) begin
          data_o  <= {sh_q[SAMPLE_W-2:0], din};
          valid_o <= 1'b1;
        end
      end
    end
  end

  // R6
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/pcm_ts_port.sv
module pcm_ts_port
  import pcm_pkg::*;
#(
  parameter int N_CH        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           bclk_i,
  input  logic                           fs_i,
  input  logic                           dr1_i,
  input  logic                           dr2_i,
  input  logic [N_CH-1:0][SAMPLE_W-1:0]  tx_data_i,
  input  logic [N_CH-1:0][SLOT_W-1:0]    tx_slot_i,
  input  logic [N_CH-1:0]                tx_hw_i,
  input  logic [N_CH-1:0][SLOT_W-1:0]    rx_slot_i,
  input  logic [N_CH-1:0]                rx_hw_i,
  output logic                           dx1_o,
  output logic                           dx1_oe_o,
  output logic                           dx2_o,
  output logic                           dx2_oe_o,
  output logic                           tsx1_no,
  output logic                           tsx2_no,
  output logic [N_CH-1:0][SAMPLE_W-1:0]  rx_data_o,
  output logic [N_CH-1:0]                rx_valid_o
);
  logic running, cfg_load, bit_tick, samp_tick;
  logic [SLOT_W:0]   slot;
  logic [BIT_W-1:0]  bitn;
  logic [1:0]        dr_s;
  logic [N_CH-1:0][SLOT_W-1:0] tx_slot_q, rx_slot_q;
  logic [N_CH-1:0]   tx_hw_q, rx_hw_q, act, act_hw, act_bit;

  pcm_frame_timer #(.SYNC_STAGES(SYNC_STAGES)) u_timer (
    .clk_i, .rst_ni, .bclk_i, .fs_i, .dr_i({dr2_i, dr1_i}),
    .running_o(running), .cfg_load_o(cfg_load), .bit_tick_o(bit_tick),
    .samp_tick_o(samp_tick), .slot_o(slot), .bit_o(bitn), .dr_o(dr_s));

  // mapping is frozen at each frame sync
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_slot_q <= '1;
      rx_slot_q <= '1;
      tx_hw_q   <= '0;
      rx_hw_q   <= '0;
    end else if (cfg_load) begin
      tx_slot_q <= tx_slot_i;
      rx_slot_q <= rx_slot_i;
      tx_hw_q   <= tx_hw_i;
      rx_hw_q   <= rx_hw_i;
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pcm_tx_lane u_tx (
      .clk_i, .rst_ni, .bit_tick_i(bit_tick), .running_i(running),
      .slot_i(slot), .bit_i(bitn), .cfg_slot_i(tx_slot_q[c]), .cfg_hw_i(tx_hw_q[c]),
      .data_i(tx_data_i[c]), .act_o(act[c]), .hw_o(act_hw[c]), .bit_o(act_bit[c]));
    pcm_rx_lane u_rx (
      .clk_i, .rst_ni, .samp_tick_i(samp_tick), .running_i(running),
      .slot_i(slot), .bit_i(bitn), .cfg_slot_i(rx_slot_q[c]), .cfg_hw_i(rx_hw_q[c]),
      .dr_i(dr_s), .data_o(rx_data_o[c]), .valid_o(rx_valid_o[c]));
  end

  // lowest channel index wins a shared slot
  always_comb begin
    dx1_o = 1'b0; dx1_oe_o = 1'b0;
    dx2_o = 1'b0; dx2_oe_o = 1'b0;
    for (int c = N_CH-1; c >= 0; c--) begin
      if (act[c] && !act_hw[c]) begin dx1_oe_o = 1'b1; dx1_o = act_bit[c]; end
      if (act[c] &&  act_hw[c]) begin dx2_oe_o = 1'b1; dx2_o = act_bit[c]; end
    end
  end

  assign tsx1_no = ~dx1_oe_o;
  assign tsx2_no = ~dx2_oe_o;

  // R2
  hiz_before_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> !dx1_oe_o && !dx2_oe_o);
endmodule

// File: tb/pcm_ts_port_test.sv
module pcm_ts_port_test;
  localparam int N_CH = 4;
  localparam int H    = 8;   // clk cycles per bclk half period
  localparam int WDOG = 190000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, bclk, fs, dr1, dr2;
  logic [N_CH-1:0][7:0] tx_data, nxt_data, snap_data;
  logic [N_CH-1:0][6:0] tx_slot, rx_slot, nxt_txs, nxt_rxs, snap_txs, snap_rxs;
  logic [N_CH-1:0]      tx_hw, rx_hw, nxt_txh, nxt_rxh, snap_txh, snap_rxh;
  logic dx1, dx1_oe, dx2, dx2_oe, tsx1_n, tsx2_n;
  logic [N_CH-1:0][7:0] rx_data;
  logic [N_CH-1:0]      rx_valid;

  pcm_ts_port #(.N_CH(N_CH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .fs_i(fs), .dr1_i(dr1), .dr2_i(dr2),
    .tx_data_i(tx_data), .tx_slot_i(tx_slot), .tx_hw_i(tx_hw),
    .rx_slot_i(rx_slot), .rx_hw_i(rx_hw),
    .dx1_o(dx1), .dx1_oe_o(dx1_oe), .dx2_o(dx2), .dx2_oe_o(dx2_oe),
    .tsx1_no(tsx1_n), .tsx2_no(tsx2_n), .rx_data_o(rx_data), .rx_valid_o(rx_valid));

  int checks = 0, failures = 0, fidx = 0, cycles = 0;
  logic [1023:0] c_oe1, c_d1, c_ts1, c_oe2, c_d2, c_ts2;
  int rx_cnt [N_CH];
  logic [7:0] rx_last [N_CH];

  // stimulus table: frame length and per-channel mapping
  localparam int             V_N   [3]       = '{8, 16, 32};
  localparam logic [6:0]     V_TXS [3][N_CH] = '{'{0, 3, 5, 7}, '{15, 8, 1, 20}, '{31, 0, 16, 127}};
  localparam logic [N_CH-1:0] V_TXH [3]      = '{4'b1010, 4'b0011, 4'b1100};
  localparam logic [6:0]     V_RXS [3][N_CH] = '{'{1, 2, 6, 7}, '{9, 127, 0, 15}, '{31, 30, 0, 100}};
  localparam logic [N_CH-1:0] V_RXH [3]      = '{4'b0110, 4'b1001, 4'b0110};

  function automatic logic [7:0] dr_byte(int f, int s, int h);
    return 8'((s * 37 + f * 11 + 5) ^ (h != 0 ? 8'hC3 : 8'h00));
  endfunction

  task automatic check(logic ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    for (int c = 0; c < N_CH; c++)
      if (rx_valid[c]) begin rx_cnt[c]++; rx_last[c] = rx_data[c]; end
    if (cycles == WDOG) begin
      failures++; checks++;
      $display("FAIL R1 watchdog: actual=%0d expected<%0d", cycles, WDOG);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic bit_period(logic f, logic d1, logic d2, int b);
    @(negedge clk); bclk = 1'b1; fs = f; dr1 = d1; dr2 = d2;
    repeat (H-1) @(negedge clk);
    if (b >= 0) begin
      c_oe1[b] = dx1_oe; c_d1[b] = dx1; c_ts1[b] = tsx1_n;
      c_oe2[b] = dx2_oe; c_d2[b] = dx2; c_ts2[b] = tsx2_n;
    end
    @(negedge clk); bclk = 1'b0;
    repeat (H-1) @(negedge clk);
  endtask

  task automatic apply_nxt();
    tx_slot = nxt_txs; tx_hw = nxt_txh; rx_slot = nxt_rxs; rx_hw = nxt_rxh;
  endtask

  task automatic load_vec(int v);
    for (int c = 0; c < N_CH; c++) begin
      nxt_txs[c] = V_TXS[v][c]; nxt_rxs[c] = V_RXS[v][c];
      nxt_data[c] = 8'(8'h5B + v * 40 + c * 71);
    end
    nxt_txh = V_TXH[v]; nxt_rxh = V_RXH[v];
  endtask

  // one frame of n slots; fs is raised in the last bit for the following frame
  task automatic run_frame(int n, int mid_bit, int chg_bit, logic [7:0] chg_val, string tag);
    snap_txs = tx_slot; snap_txh = tx_hw; snap_rxs = rx_slot; snap_rxh = rx_hw;
    snap_data = tx_data;
    for (int c = 0; c < N_CH; c++) rx_cnt[c] = 0;
    for (int b = 0; b < n * 8; b++) begin
      if (b == mid_bit) apply_nxt();
      if (b == chg_bit) tx_data[0] = chg_val;
      if (b == n * 8 - 2) begin apply_nxt(); tx_data = nxt_data; end
      bit_period(b == n * 8 - 1, dr_byte(fidx, b / 8, 0)[7 - b % 8],
                 dr_byte(fidx, b / 8, 1)[7 - b % 8], b);
    end
    for (int h = 0; h < 2; h++) begin
      int bad = 0, ab = 0, eb = 0;
      for (int b = 0; b < n * 8; b++) begin
        logic eoe = 1'b0, ed = 1'b0, aoe, ad, ats;
        for (int c = N_CH-1; c >= 0; c--)
          if (int'(snap_txh[c]) == h && int'(snap_txs[c]) < n && int'(snap_txs[c]) == b / 8) begin
            eoe = 1'b1; ed = snap_data[c][7 - b % 8];
          end
        aoe = h == 0 ? c_oe1[b] : c_oe2[b];
        ad  = h == 0 ? c_d1[b]  : c_d2[b];
        ats = h == 0 ? c_ts1[b] : c_ts2[b];
        if (aoe != eoe || ats != !eoe || (eoe && ad != ed)) begin
          if (bad == 0) begin ab = {aoe, ats, ad}; eb = {eoe, !eoe, ed}; end
          bad++;
        end
      end
      check(bad == 0, $sformatf("%s R3 R4 R5", tag), $sformatf("hw%0d first bad {oe,tsx,d}", h + 1), ab, eb);
    end
    for (int c = 0; c < N_CH; c++) begin
      int en = int'(snap_rxs[c]) < n;
      logic [7:0] eb = dr_byte(fidx, int'(snap_rxs[c]), int'(snap_rxh[c]));
      check(rx_cnt[c] == en, $sformatf("%s R6 R7", tag), $sformatf("ch%0d strobes", c), rx_cnt[c], en);
      if (en != 0)
        check(rx_last[c] == eb, $sformatf("%s R6", tag), $sformatf("ch%0d byte", c), rx_last[c], eb);
    end
    fidx++;
  endtask

  initial begin
    rst_n = 1'b0; bclk = 1'b0; fs = 1'b0; dr1 = 1'b0; dr2 = 1'b0;
    for (int c = 0; c < N_CH; c++) rx_cnt[c] = 0;
    load_vec(0); apply_nxt(); tx_data = nxt_data;
    repeat (4) @(negedge clk);
    check(!dx1_oe && !dx2_oe && tsx1_n && tsx2_n && rx_valid == '0, "R2", "reset outputs",
          {dx1_oe, dx2_oe, tsx1_n, tsx2_n}, 4'b0011);
    rst_n = 1'b1;

    // R2: bit clock runs, no sync yet, slot 0 mapped
    for (int b = 0; b < 16; b++) bit_period(1'b0, 1'b1, 1'b1, b);
    check(c_oe1[15:0] == '0 && c_ts1[15:0] == '1, "R2", "dx1 before sync", int'(c_oe1[15:0]), 0);
    check(c_oe2[15:0] == '0 && c_ts2[15:0] == '1, "R2", "dx2 before sync", int'(c_oe2[15:0]), 0);
    check(rx_cnt[0] + rx_cnt[1] + rx_cnt[2] + rx_cnt[3] == 0, "R2", "rx before sync",
          rx_cnt[0] + rx_cnt[1] + rx_cnt[2] + rx_cnt[3], 0);

    bit_period(1'b1, 1'b0, 1'b0, -1);   // first frame sync

    // table walk: frame length changes each frame (R1, R7)
    for (int v = 0; v < 3; v++) begin
      if (v < 2) load_vec(v + 1);
      else begin
        nxt_txs = '{7'd127, 7'd127, 7'd127, 7'd6}; nxt_txh = 4'b0000;
        nxt_rxs = '{7'd127, 7'd127, 7'd127, 7'd6}; nxt_rxh = 4'b0000;
        nxt_data = {8'h11, 8'h22, 8'h33, 8'hA7};
      end
      run_frame(V_N[v], -1, -1, 8'h00, "R1");
    end

    // R8: highways flipped mid-frame, old mapping still expected
    nxt_txh = 4'b0001; nxt_rxh = 4'b0001;
    run_frame(8, 20, -1, 8'h00, "R8");
    // R9: data changed in bit 3 of channel 0's slot 6; R8 new mapping now in force
    nxt_txs = '{7'd126, 7'd0, 7'd64, 7'd127}; nxt_txh = 4'b1001;
    nxt_rxs = '{7'd126, 7'd63, 7'd127, 7'd0}; nxt_rxh = 4'b0101;
    nxt_data = {8'h3C, 8'h81, 8'hFF, 8'h96};
    run_frame(8, -1, 51, 8'h0F, "R8 R9");
    // R10: 128-slot frame, slot 127 in both directions
    run_frame(128, -1, -1, 8'h00, "R10");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule